// File: doc/BRIEF.md
# Backlight Level / PWM Duty Converter

This block translates between a normalised brightness level and the active count of a backlight PWM whose period register has a programmable width. The forward direction turns an unsigned 1.16 fixed-point level (one integer bit, sixteen fraction bits) into the active count that yields that brightness for the given period. The reverse direction reads a programmed active count back into a 16-bit level. Both directions round half up at a bit position chosen by the period width, so a level can be written and then read back with little drift.

Requests arrive on a valid/ready handshake. A direction bit chooses the path. The forward path finishes in two cycles. The reverse path runs a restoring divider for one cycle per dividend bit, so its latency is fixed but longer. While a request is in flight the block lowers `req_ready` and takes no new work. Each result appears in an output register together with an 8-bit condensed brightness byte, and `res_valid` pulses for exactly one cycle.

The controller has five states:
- `S_IDLE`: waits for a request.
- `S_FWD`: forms the forward product and rounds it.
- `S_DIV`: performs one quotient bit per cycle.
- `S_RND`: halves and rounds the quotient, scales it back by the period and rounds the result.
- `S_DONE`: presents the result.

The transitions are:
- IDLE→FWD on an accepted request with direction 0.
- IDLE→DIV on an accepted request with direction 1.
- FWD→DONE after one cycle.
- DIV→RND after the last quotient bit.
- RND→DONE after one cycle.
- DONE→IDLE after one cycle.

Top module: `bl_duty_conv`

## Requirements
- R1: A `req_bitcnt` of 0 selects a period width n of 16. The values 1 to 15 select that width directly. This applies to both directions.
- R2: Before any other use, the period is reduced to its low n bits. Higher period bits never affect a result.
- R3: Forward (`req_dir`=0): P = level × masked period. The result is ((P >> n) mod 2^16 + bit n−1 of P) mod 2^16.
- R4: Reverse (`req_dir`=1) with `req_frac`=0: the duty is ANDed with ((2^n−1) << (16−n)) mod 2^16. With `req_frac`=1 all 16 duty bits are kept.
- R5: Reverse: a masked period of 0 is treated as 0xFFFF in every later step.
- R6: Reverse: the steps are as follows. The result is taken mod 2^16.
  - q = floor((duty << (n+1)) / period).
  - q' = (q+1) >> 1.
  - P = q' × period.
  - The result is (P >> n) + bit n−1 of P.
- R7: `res_byte` depends on the direction.
  - Forward: 0xFF when level bit 16 is set, otherwise level bits 15:8.
  - Reverse: bits 15:8 of the recovered level.
- R8: After reset `req_ready`=1 and `res_valid`=0. Accepting a request drops `req_ready` until the result has been presented. A `req_valid` seen while `req_ready` is low is ignored and produces no result. Every accepted request produces exactly one result.
- R9: `res_valid` is high for a single cycle. In the next cycle `req_ready` is high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request will be taken |
| req_dir | input | 1 | 0 = level to duty, 1 = duty to level |
| req_level | input | W+1 (17) | 1.16 brightness level (forward) |
| req_duty | input | W (16) | Programmed active count (reverse) |
| req_period | input | W (16) | PWM period register value |
| req_bitcnt | input | log2(W) (4) | Period width code, 0 means W |
| req_frac | input | 1 | Reverse: keep fractional duty bits |
| res_valid | output | 1 | One-cycle result strobe |
| res_value | output | W (16) | Duty count or recovered level |
| res_byte | output | 8 | Condensed 8-bit brightness |

## Verification
The bench builds the block with its default W=16. This gives a 33-bit dividend, a 33-cycle divide and width codes 0 to 15. Every period width from 1 to 16 is then reachable, including the code-0 case and the widths where the substituted 0xFFFF period exceeds the masked range.

For each width, the bench runs forward requests at full, saturated and tiny levels. It also runs reverse requests with fractional mode on and off, and with a period whose low bits are all zero. A burst of `req_valid` during a long divide confirms that no extra result is produced.

// File: rtl/bl_conv_pkg.sv
package bl_conv_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_FWD,
        S_DIV,
        S_RND,
        S_DONE
    } conv_state_e;
endpackage

// File: rtl/bl_fwd_math.sv
// Level-to-duty arithmetic: scale by the masked period, drop n bits, round half up.
module bl_fwd_math #(
    parameter int W  = 16,
    parameter int NW = $clog2(W) + 1
) (
    input  logic [W:0]    level,
    input  logic [W-1:0]  per_m,
    input  logic [NW-1:0] n,
    output logic [W-1:0]  duty
);
    localparam int PW = 2 * W + 1;

    logic [PW-1:0] prod;

    assign prod = PW'(level) * PW'(per_m);
    assign duty = W'(prod >> n) + W'(prod[n - NW'(1)]);
endmodule

// File: rtl/bl_rev_round.sv
// Reverse tail: halve-and-round the quotient, rescale by the period, round at bit n-1.
module bl_rev_round #(
    parameter int W     = 16,
    parameter int NW    = $clog2(W) + 1,
    parameter int DVD_W = 2 * W + 1
) (
    input  logic [DVD_W-1:0] quo,
    input  logic [W-1:0]     per,
    input  logic [NW-1:0]    n,
    output logic [W-1:0]     level
);
    localparam int PW = DVD_W + W;

    logic [DVD_W-1:0] q_half;
    logic [PW-1:0]    prod;

    assign q_half = DVD_W'(({1'b0, quo} + (DVD_W + 1)'(1)) >> 1);
    assign prod   = PW'(q_half) * PW'(per);
    assign level  = W'(prod >> n) + W'(prod[n - NW'(1)]);
endmodule

// File: rtl/bl_rdiv.sv
// Restoring divider datapath; the parent FSM sequences load and step.
module bl_rdiv #(
    parameter int DW = 33,
    parameter int VW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [DW-1:0] dividend,
    input  logic [VW-1:0] divisor,
    output logic [DW-1:0] quotient
);
    logic [DW-1:0] acc;
    logic [VW-1:0] rem;
    logic [VW:0]   trial;
    logic          fits;

    assign trial    = {rem, acc[DW-1]};
    assign fits     = trial >= {1'b0, divisor};
    assign quotient = acc;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
            rem <= '0;
        end else if (load) begin
            acc <= dividend;
            rem <= '0;
        end else if (step) begin
            acc <= {acc[DW-2:0], fits};
            rem <= fits ? VW'(trial - {1'b0, divisor}) : VW'(trial);
        end
    end

    // R6: partial remainder always stays below the divisor
    p_rem_below_r6: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (rem < divisor));
endmodule

// File: rtl/bl_duty_conv.sv
module bl_duty_conv
    import bl_conv_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_dir,
    input  logic [W:0]           req_level,
    input  logic [W-1:0]         req_duty,
    input  logic [W-1:0]         req_period,
    input  logic [$clog2(W)-1:0] req_bitcnt,
    input  logic                 req_frac,
    output logic                 res_valid,
    output logic [W-1:0]         res_value,
    output logic [7:0]           res_byte
);
    localparam int NW    = $clog2(W) + 1;
    localparam int DVD_W = 2 * W + 1;
    localparam int CW    = $clog2(DVD_W + 1);

    conv_state_e state, nxt;

    logic          dir_q;
    logic [NW-1:0] n_q;
    logic [W:0]    lvl_q;
    logic [W-1:0]  per_q;
    logic [CW-1:0] cnt;

    logic [NW-1:0]    n_in;
    logic [W-1:0]     pmask, dmask, per_m, duty_m, per_r;
    logic [DVD_W-1:0] dividend, quo;
    logic [W-1:0]     fwd_duty, rev_val;
    logic             accept, div_load, div_step;

    // request decode: width code, period mask, duty mask, zero-period substitute
    assign n_in     = (req_bitcnt == '0) ? NW'(W) : {1'b0, req_bitcnt};
    assign pmask    = (W'(1) << n_in) - W'(1);
    assign per_m    = req_period & pmask;
    assign dmask    = req_frac ? '1 : (pmask << (NW'(W) - n_in));
    assign duty_m   = req_duty & dmask;
    assign per_r    = (per_m == '0) ? '1 : per_m;
    assign dividend = DVD_W'(duty_m) << (n_in + NW'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: if (req_valid) nxt = req_dir ? S_DIV : S_FWD;
            S_FWD:  nxt = S_DONE;
            S_DIV:  if (cnt == CW'(DVD_W - 1)) nxt = S_RND;
            S_RND:  nxt = S_DONE;
            S_DONE: nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    always_comb begin
        req_ready = (state == S_IDLE);
        res_valid = (state == S_DONE);
        accept    = (state == S_IDLE) && req_valid;
        div_load  = accept && req_dir;
        div_step  = (state == S_DIV);
    end

    bl_fwd_math #(.W(W), .NW(NW)) u_fwd (
        .level (lvl_q),
        .per_m (per_q),
        .n     (n_q),
        .duty  (fwd_duty)
    );

    bl_rdiv #(.DW(DVD_W), .VW(W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (div_load),
        .step     (div_step),
        .dividend (dividend),
        .divisor  (per_q),
        .quotient (quo)
    );

    bl_rev_round #(.W(W), .NW(NW), .DVD_W(DVD_W)) u_rnd (
        .quo   (quo),
        .per   (per_q),
        .n     (n_q),
        .level (rev_val)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q     <= 1'b0;
            n_q       <= NW'(W);
            lvl_q     <= '0;
            per_q     <= '0;
            cnt       <= '0;
            res_value <= '0;
            res_byte  <= '0;
        end else begin
            if (accept) begin
                dir_q <= req_dir;
                n_q   <= n_in;
                lvl_q <= req_level;
                per_q <= req_dir ? per_r : per_m;
                cnt   <= '0;
            end
            if (div_step) cnt <= cnt + CW'(1);
            if (state == S_FWD) begin
                res_value <= fwd_duty;
                res_byte  <= lvl_q[W] ? 8'hFF : lvl_q[W-1 -: 8];
            end
            if (state == S_RND) begin
                res_value <= rev_val;
                res_byte  <= rev_val[W-1 -: 8];
            end
        end
    end

    // R8: an accepted request makes the block busy
    p_accept_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R9: single-cycle strobe, then idle again
    p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> (!res_valid && req_ready));

    // R5: the divisor is never zero while dividing
    p_per_nz_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DIV) |-> (per_q != '0));

    // R7: a saturated forward level reports a full byte
    p_byte_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !dir_q && lvl_q[W]) |-> (res_byte == 8'hFF));
endmodule

// File: tb/tb_bl_duty_conv.sv
module tb_bl_duty_conv;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_dir = 1'b0;
    logic [16:0] req_level = '0;
    logic [15:0] req_duty = '0;
    logic [15:0] req_period = '0;
    logic [3:0]  req_bitcnt = '0;
    logic        req_frac = 1'b0;
    logic        res_valid;
    logic [15:0] res_value;
    logic [7:0]  res_byte;

    int total = 0;
    int bad = 0;
    int pushed = 0;
    int seen = 0;
    bit finished = 0;
    bit chk_after = 0;

    logic [23:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    bl_duty_conv #(.W(16)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_dir(req_dir), .req_level(req_level), .req_duty(req_duty),
        .req_period(req_period), .req_bitcnt(req_bitcnt), .req_frac(req_frac),
        .res_valid(res_valid), .res_value(res_value), .res_byte(res_byte)
    );

    function automatic logic [15:0] m_fwd(logic [16:0] lv, logic [15:0] per, int bc);
        int n = (bc == 0) ? 16 : bc;
        longint pm = (64'd1 << n) - 1;
        longint p  = longint'(per) & pm;
        longint pr = longint'(lv) * p;
        longint r  = ((pr >> n) & 64'hFFFF) + ((pr >> (n - 1)) & 1);
        return r[15:0];
    endfunction

    function automatic logic [15:0] m_rev(logic [15:0] du, logic [15:0] per, int bc, bit fr);
        int n = (bc == 0) ? 16 : bc;
        longint pm = (64'd1 << n) - 1;
        longint p  = longint'(per) & pm;
        longint d  = fr ? longint'(du) : (longint'(du) & ((pm << (16 - n)) & 64'hFFFF));
        longint q, pr, r;
        if (p == 0) p = 64'hFFFF;
        q  = (d << (1 + n)) / p;
        q  = (q + 1) >> 1;
        pr = q * p;
        r  = (pr >> n) + ((pr >> (n - 1)) & 1);
        return r[15:0];
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // driver: computes the expectation, queues it, then issues the request
    task automatic send(string tag, bit dir, logic [16:0] lv, logic [15:0] du,
                        logic [15:0] per, int bc, bit fr);
        logic [15:0] v;
        logic [7:0]  b;
        if (!dir) begin
            v = m_fwd(lv, per, bc);
            b = lv[16] ? 8'hFF : lv[15:8];
        end else begin
            v = m_rev(du, per, bc, fr);
            b = v[15:8];
        end
        exp_q.push_back({b, v});
        tag_q.push_back(tag);
        pushed++;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid  = 1'b1;
        req_dir    = dir;
        req_level  = lv;
        req_duty   = du;
        req_period = per;
        req_bitcnt = 4'(bc);
        req_frac   = fr;
        @(negedge clk);
        req_valid  = 1'b0;
    endtask

    // monitor: pops and compares each result, then checks the strobe ended (R9)
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (chk_after) begin
                chk_after = 0;
                check("R9 strobe/ready", {30'd0, res_valid, req_ready}, 32'd1);
            end
            if (res_valid) begin
                seen++;
                chk_after = 1;
                if (exp_q.size() == 0) begin
                    check("R8 unexpected result", 32'd1, 32'd0);
                end else begin
                    logic [23:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(t, {16'd0, res_value}, {16'd0, e[15:0]});
                    check("R7 byte", {24'd0, res_byte}, {24'd0, e[23:16]});
                end
            end
        end
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R8 reset ready/valid", {30'd0, req_ready, res_valid}, 32'd2);
        rst_n = 1'b1;

        for (int bc = 0; bc < 16; bc++) begin
            int n = (bc == 0) ? 16 : bc;
            logic [15:0] full = 16'((32'd1 << n) - 1);
            string ft = (bc == 0) ? "R1 fwd" : "R3 fwd";
            send(ft, 0, 17'h10000, 16'h0, full, bc, 0);
            send(ft, 0, 17'h0EFF0, 16'h0, 16'h0024 & full, bc, 0);
            send(ft, 0, 17'h00001, 16'h0, full, bc, 0);
            send("R2 fwd period high bits", 0, 17'h08000, 16'h0, 16'hA5C3, bc, 0);
            send("R7 fwd saturated byte", 0, 17'h1ABCD, 16'h0, 16'h7F31, bc, 0);
            send("R4 rev frac off", 1, 17'h0, 16'hFFFF, 16'h9A3B, bc, 0);
            send("R4 rev frac on", 1, 17'h0, 16'hC37D, 16'h9A3B, bc, 1);
            send("R5 rev zero period", 1, 17'h0, 16'h8421, 16'(~full), bc, 1);
            send((bc == 0) ? "R1 rev" : "R6 rev", 1, 17'h0, 16'h5A5A, 16'h0FA0, bc, 0);
        end

        // R8: requests offered while busy must be ignored
        send("R6 rev busy-case", 1, 17'h0, 16'h1234, 16'h00FF, 8, 1);
        @(negedge clk);
        req_valid  = 1'b1;
        req_dir    = 1'b0;
        req_level  = 17'h1FFFF;
        req_period = 16'hFFFF;
        repeat (10) @(negedge clk);
        req_valid  = 1'b0;

        for (int w = 0; w < 2000 && exp_q.size() != 0; w++) @(negedge clk);
        repeat (4) @(negedge clk);
        check("R8 one result per request", seen, pushed);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule